// File: doc/BRIEF.md
# Back-Pressure Node Controller

This block sequences one node of a distributed system whose nodes run on their own local clock enables. It wraps a local compute step: it decides on which local tick the step may run, and on which local tick the result of that step may be handed to the consumers. Every input link and every acknowledge link carries an alternating tag bit. A link counts as fresh when its tag differs from the tag seen at the last reference event.

The controller has two phases. In the waiting phase it skips ticks until every input link is fresh. On the first tick where they all are, it strobes execute together with an acknowledge towards the producers and moves to the ready phase. The compute step's result is latched on that tick. In the ready phase it skips ticks until every consumer has acknowledged. It then strobes publish with the latched result and returns to waiting. A result is never computed and published on the same tick, and a node with no consumers publishes on the first tick after its execute.

Top module: `bp_node_ctrl`

## Requirements
- R1: After reset the controller is in the waiting phase with both reference tag sets at 0, and no strobe fires while all tags are 0.
- R2: In the waiting phase, `exec_pulse` is high in a cycle exactly when `tick` is high and every bit of `in_tag` differs from the bit captured at the last execute (0 after reset).
- R3: `ack_pulse` is high in exactly the cycles where `exec_pulse` is high.
- R4: After an execute, no further execute occurs until a publish has occurred, even when all inputs are fresh again.
- R5: In the ready phase, `pub_pulse` is high in a cycle exactly when `tick` is high and every bit of `ack_tag` differs from the bit captured at the last publish (0 after reset).
- R6: `pub_data` on a publish equals the value of `res_in` in the cycle of the preceding execute, and `pub_data` changes only in the cycle after an execute.
- R7: `exec_pulse` and `pub_pulse` are never high in the same cycle.
- R8: While `tick` is low, no strobe fires and the phase and reference tags do not change.
- R9: A single stale link blocks the transition: one input with an unchanged tag blocks execute, one acknowledge with an unchanged tag blocks publish.
- R10: With `M_OUT` = 0, the all-acknowledged condition is true, so publish happens on the first tick after an execute.
- R11: Freshness is relative to the last execute or publish, not to tag changes: a tag that toggles twice between two ticks is stale, and a tag toggled while the node was in the ready phase is still fresh when the waiting phase resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Local clock enable of the node |
| in_data | input | N_IN*DW | Input link payloads, tags removed |
| in_tag | input | N_IN | Alternating tag bit per input link |
| ack_tag | input | AW | Alternating tag bit per acknowledge link (AW = max(M_OUT,1)) |
| res_in | input | RW | Result of the compute step for the current `exec_data` |
| exec_pulse | output | 1 | Run the compute step this cycle |
| exec_data | output | N_IN*DW | Operands for the compute step |
| ack_pulse | output | 1 | Acknowledge to all producers |
| pub_pulse | output | 1 | Publish the held result to consumers |
| pub_data | output | RW | Result held since the last execute |

## Verification
The bench targets a partial set of fresh inputs or acknowledges: a design that ANDs too few links would fire early. It targets fresh inputs arriving while in the ready phase: a design that ignored the phase would execute twice and overwrite an unpublished result. A tag toggled twice between ticks must read as stale, which catches a design that tracks edges instead of comparing with the tag captured at the last event. A second instance with no consumers must publish on the next tick, where a zero-width reduction taken as false would lock the node up.

// File: rtl/bpn_pkg.sv
package bpn_pkg;
  typedef enum logic {
    PH_WAIT  = 1'b0,
    PH_READY = 1'b1
  } bpn_phase_e;

  // A link is fresh when its tag differs from the reference copy.
  function automatic logic tag_is_fresh(input logic tag, input logic ref_tag);
    return tag ^ ref_tag;
  endfunction
endpackage

// File: rtl/bpn_fresh_track.sv
module bpn_fresh_track #(
  parameter int W = 2,
  localparam int LW = (W > 0) ? W : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] tags,
  input  logic          capture,
  output logic          all_fresh
);
  import bpn_pkg::*;

  generate
    if (W == 0) begin : g_empty
      logic unused_inputs;
      assign unused_inputs = ^{tags, capture, clk, rst_n};
      assign all_fresh = 1'b1;
    end else begin : g_links
      logic [W-1:0] ref_q;
      logic [W-1:0] fresh_v;
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign fresh_v[i] = tag_is_fresh(tags[i], ref_q[i]);
      end
      always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= '0;
        else if (capture) ref_q <= tags;
      end
      assign all_fresh = &fresh_v;
    end
  endgenerate
endmodule

// File: rtl/bpn_result_hold.sv
module bpn_result_hold #(
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] d,
  output logic [RW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/bp_node_ctrl.sv
module bp_node_ctrl #(
  parameter int N_IN  = 3,
  parameter int DW    = 8,
  parameter int M_OUT = 2,
  parameter int RW    = 16,
  localparam int AW   = (M_OUT > 0) ? M_OUT : 1,
  localparam int IW   = N_IN * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [IW-1:0] in_data,
  input  logic [N_IN-1:0] in_tag,
  input  logic [AW-1:0] ack_tag,
  input  logic [RW-1:0] res_in,
  output logic          exec_pulse,
  output logic [IW-1:0] exec_data,
  output logic          ack_pulse,
  output logic          pub_pulse,
  output logic [RW-1:0] pub_data
);
  import bpn_pkg::*;

  bpn_phase_e phase_q;
  logic in_all_fresh;
  logic ack_all_fresh;
  logic fire_exec;
  logic fire_pub;

  bpn_fresh_track #(.W(N_IN)) u_in_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .tags      (in_tag),
    .capture   (fire_exec),
    .all_fresh (in_all_fresh)
  );

  bpn_fresh_track #(.W(M_OUT)) u_ack_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .tags      (ack_tag),
    .capture   (fire_pub),
    .all_fresh (ack_all_fresh)
  );

  assign fire_exec = tick && (phase_q == PH_WAIT)  && in_all_fresh;
  assign fire_pub  = tick && (phase_q == PH_READY) && ack_all_fresh;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_WAIT;
    else if (fire_exec) phase_q <= PH_READY;
    else if (fire_pub) phase_q <= PH_WAIT;
  end

  bpn_result_hold #(.RW(RW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire_exec),
    .d     (res_in),
    .q     (pub_data)
  );

  assign exec_pulse = fire_exec;
  assign ack_pulse  = fire_exec;
  assign pub_pulse  = fire_pub;
  assign exec_data  = in_data;
endmodule

// File: rtl/bpn_checker.sv
module bpn_checker #(
  parameter int RW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          exec_pulse,
  input logic          pub_pulse,
  input logic [RW-1:0] pub_data
);
  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_pulse && pub_pulse));

  p_idle_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !exec_pulse && !pub_pulse);

  p_no_double_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |=> !exec_pulse);

  p_no_double_pub_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pub_pulse |=> !pub_pulse);

  p_result_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_pulse |=> $stable(pub_data));
endmodule

bind bp_node_ctrl bpn_checker #(.RW(RW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .exec_pulse (exec_pulse),
  .pub_pulse  (pub_pulse),
  .pub_data   (pub_data)
);

// File: tb/tb_bp_node_ctrl.sv
module tb_bp_node_ctrl;
  localparam int N_IN = 3;
  localparam int DW   = 8;
  localparam int RW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [N_IN*DW-1:0] in_data = '0;
  logic [N_IN-1:0] in_tag = '0;
  logic [1:0] ack_tag = '0;
  logic [RW-1:0] res_in;

  logic exec_a, ack_a, pub_a, exec_b, ack_b, pub_b;
  logic [N_IN*DW-1:0] xd_a, xd_b;
  logic [RW-1:0] pd_a, pd_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign res_in = in_data[RW-1:0] ^ 16'h5A3C;

  bp_node_ctrl #(.N_IN(N_IN), .DW(DW), .M_OUT(2), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data), .in_tag(in_tag),
    .ack_tag(ack_tag), .res_in(res_in), .exec_pulse(exec_a), .exec_data(xd_a),
    .ack_pulse(ack_a), .pub_pulse(pub_a), .pub_data(pd_a));

  bp_node_ctrl #(.N_IN(N_IN), .DW(DW), .M_OUT(0), .RW(RW)) dut0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data), .in_tag(in_tag),
    .ack_tag(1'b0), .res_in(res_in), .exec_pulse(exec_b), .exec_data(xd_b),
    .ack_pulse(ack_b), .pub_pulse(pub_b), .pub_data(pd_b));

  // Reference model built from the requirements, one per instance.
  bit m_ready [2];
  logic [N_IN-1:0] m_in_ref [2];
  logic [1:0] m_ack_ref;
  logic [RW-1:0] sb_a [$];
  logic [RW-1:0] sb_b [$];

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle's inputs, then compare the strobes and update the model.
  task automatic step(input logic t, input logic [N_IN-1:0] flip_in,
                      input logic [1:0] flip_ack, input string req);
    logic ex [2];
    logic pb [2];
    logic [RW-1:0] got;
    @(negedge clk);
    tick = t;
    in_tag = in_tag ^ flip_in;
    ack_tag = ack_tag ^ flip_ack;
    in_data = in_data + 24'h010203;
    #2;
    for (int k = 0; k < 2; k++) begin
      ex[k] = t && !m_ready[k] && ((in_tag ^ m_in_ref[k]) == '1);
      pb[k] = t && m_ready[k] && (k == 1 || ((ack_tag ^ m_ack_ref) == 2'b11));
    end
    check(req, "exec A", {31'd0, exec_a}, {31'd0, ex[0]});
    check("R3", "ack A", {31'd0, ack_a}, {31'd0, ex[0]});
    check(req, "pub A", {31'd0, pub_a}, {31'd0, pb[0]});
    check("R10", "exec B", {31'd0, exec_b}, {31'd0, ex[1]});
    check("R10", "pub B", {31'd0, pub_b}, {31'd0, pb[1]});
    check("R7", "overlap A", {31'd0, exec_a & pub_a}, 32'd0);
    if (ex[0]) begin
      check("R2", "exec_data A", xd_a, in_data);
      sb_a.push_back(res_in);
    end
    if (ex[1]) sb_b.push_back(res_in);
    if (pb[0] && sb_a.size() > 0) begin
      got = sb_a.pop_front();
      check("R6", "pub_data A", {16'd0, pd_a}, {16'd0, got});
    end
    if (pb[1] && sb_b.size() > 0) begin
      got = sb_b.pop_front();
      check("R6", "pub_data B", {16'd0, pd_b}, {16'd0, got});
    end
    for (int k = 0; k < 2; k++) begin
      if (ex[k]) begin m_ready[k] = 1'b1; m_in_ref[k] = in_tag; end
      else if (pb[k]) begin
        m_ready[k] = 1'b0;
        if (k == 0) m_ack_ref = ack_tag;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin m_ready[k] = 1'b0; m_in_ref[k] = '0; end
    m_ack_ref = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 3'b000, 2'b00, "R1");   // nothing fresh after reset
    step(1'b1, 3'b011, 2'b00, "R9");   // one input still stale
    step(1'b0, 3'b100, 2'b00, "R8");   // all fresh but no tick
    step(1'b1, 3'b000, 2'b00, "R2");   // execute; B executes too
    step(1'b1, 3'b111, 2'b00, "R4");   // fresh inputs in ready: hold; B publishes (R10)
    step(1'b1, 3'b000, 2'b01, "R9");   // one acknowledge stale
    step(1'b0, 3'b000, 2'b10, "R8");   // all acks fresh, no tick
    step(1'b1, 3'b000, 2'b00, "R5");   // publish
    step(1'b1, 3'b000, 2'b00, "R11");  // inputs flipped during ready still fresh
    step(1'b1, 3'b000, 2'b11, "R5");   // publish again
    step(1'b1, 3'b001, 2'b00, "R11");
    step(1'b1, 3'b111, 2'b00, "R11");  // input 0 toggled twice: stale
    step(1'b1, 3'b001, 2'b00, "R2");   // now fresh
    for (int n = 0; n < 40; n++)
      step((n % 3) != 2, 3'(n * 5 + 1), 2'(n + 2), "R2");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule